// File: doc/BRIEF.md
# Real-time clock alarm comparator and interrupt flags

This block sits beside the timekeeping counters of a real-time clock. It holds three programmable alarm bytes for seconds, minutes and hours and compares them with the running time fields. The comparison happens each time the counters report that an update has ended. A wildcard code in any alarm byte makes that field match every value, so an alarm can fire once per second, minute, hour or day.

Three events are recorded in one flag register: a periodic tick, an alarm match and an update-ended strobe. A summary bit in that register shows whether any recorded event has its enable set, and the interrupt request output follows that bit. Software reads the flag register through a plain address, data and strobe port. The read returns the flags and clears them in the same access, so one read both services and acknowledges the interrupt.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The seconds, minutes and hours alarm bytes are written and read back at register indices 1, 3 and 5. All three are 0 after reset.
- R2: An alarm byte whose bits 7 and 6 are both 1 matches any value of its time field.
- R3: The alarm flag (flag register bit 5) is set only in the cycle after an update-ended strobe, and only if all three fields match at that strobe. A match with no strobe sets nothing.
- R4: An update-ended strobe sets the update flag (bit 4) on the next clock edge.
- R5: A periodic tick strobe sets the periodic flag (bit 6) on the next clock edge.
- R6: Event flags are recorded whatever their enable bits are. Bit 7 reads 1 exactly when some flag among bits 6..4 is set and its enable input (periodic, alarm or update) is high.
- R7: A read of the flag register (index 12) returns its current value, and at the end of that cycle it clears every flag bit.
- R8: An event that arrives in the same cycle as a flag-register read is still set after the clear.
- R9: The interrupt output is active high and always equals bit 7 of the flag register.
- R10: Bits 3..0 of the flag register read as 0. Unmapped indices read as 0.
- R11: After reset all flags are clear and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec | input | 8 | Running seconds value |
| cur_min | input | 8 | Running minutes value |
| cur_hour | input | 8 | Running hours value |
| upd_stb | input | 1 | One-cycle update-ended strobe |
| per_tick | input | 1 | One-cycle periodic tick strobe |
| en_per | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update-ended interrupt enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench sets the time to exactly the alarm value and holds it without a strobe. A design that compared continuously would raise the alarm flag there. It mixes wildcard and exact bytes with one field deliberately mismatched, which catches a design that treats only 0xFF as the wildcard or that ORs the field matches together. It sets events with every enable low to show that flags record regardless, and then toggles an enable to show that the summary bit and the output follow it. It fires a periodic tick in the very cycle of a flag read: a clear that won over the event would lose that tick. After each read it reads again to confirm the clear.

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] IDX_ASEC = AW'(1),
  parameter logic [AW-1:0] IDX_AMIN = AW'(3),
  parameter logic [AW-1:0] IDX_AHR  = AW'(5),
  parameter logic [AW-1:0] IDX_FLAG = AW'(12)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic          upd_stb,
  input  logic          per_tick,
  input  logic          en_per,
  input  logic          en_alm,
  input  logic          en_upd,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int LOWZ = DW - 4;

  logic [DW-1:0] al_s, al_m, al_h;
  logic fl_p, fl_a, fl_u;

  function automatic logic fmatch(input logic [DW-1:0] a, input logic [DW-1:0] c);
    return (&a[DW-1:DW-2]) || (a == c);
  endfunction

  wire all_hit = fmatch(al_s, cur_sec) && fmatch(al_m, cur_min) && fmatch(al_h, cur_hour);
  wire clr     = rd_en && (addr == IDX_FLAG);
  wire summary = (fl_p & en_per) | (fl_a & en_alm) | (fl_u & en_upd);
  wire [DW-1:0] flag_byte = {summary, fl_p, fl_a, fl_u, LOWZ'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_s <= '0;
      al_m <= '0;
      al_h <= '0;
      fl_p <= 1'b0;
      fl_a <= 1'b0;
      fl_u <= 1'b0;
    end else begin
      if (wr_en && addr == IDX_ASEC) al_s <= wdata;
      if (wr_en && addr == IDX_AMIN) al_m <= wdata;
      if (wr_en && addr == IDX_AHR)  al_h <= wdata;
      fl_p <= per_tick | (fl_p & ~clr);
      fl_a <= (upd_stb & all_hit) | (fl_a & ~clr);
      fl_u <= upd_stb | (fl_u & ~clr);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == IDX_ASEC)      rdata = al_s;
    else if (addr == IDX_AMIN) rdata = al_m;
    else if (addr == IDX_AHR)  rdata = al_h;
    else if (addr == IDX_FLAG) rdata = flag_byte;
  end

  assign irq = summary;

  p_alarm_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_ASEC) |=> (al_s == $past(wdata)));

  p_alarm_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_a) |-> $past(upd_stb));

  p_upd_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> fl_u);

  p_tick_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> fl_p);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !per_tick && !upd_stb) |=> (!fl_p && !fl_a && !fl_u));

  p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fl_p || fl_a || fl_u));

  p_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == IDX_FLAG) |-> (rdata[3:0] == 4'h0));
endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cur_sec = 8'h0, cur_min = 8'h0, cur_hour = 8'h0;
  logic upd_stb = 1'b0, per_tick = 1'b0;
  logic en_per = 1'b0, en_alm = 1'b0, en_upd = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h0;
  logic [7:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq dut (.clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .upd_stb(upd_stb), .per_tick(per_tick), .en_per(en_per),
    .en_alm(en_alm), .en_upd(en_upd), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; addr = 4'h0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd1, d);  chk("R11 asec", d, 8'h00);
    rd(4'd3, d);  chk("R11 amin", d, 8'h00);
    rd(4'd5, d);  chk("R11 ahr", d, 8'h00);
    rd(4'd12, d); chk("R11 flags", d, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_alarm_regs();
    logic [7:0] d;
    wr(4'd1, 8'h45); wr(4'd3, 8'h30); wr(4'd5, 8'h07);
    rd(4'd1, d); chk("R1 asec", d, 8'h45);
    rd(4'd3, d); chk("R1 amin", d, 8'h30);
    rd(4'd5, d); chk("R1 ahr", d, 8'h07);
    rd(4'd2, d); chk("R10 unmapped", d, 8'h00);
  endtask

  task automatic t_update_no_enable();
    logic [7:0] d;
    cur_sec = 8'h10; cur_min = 8'h30; cur_hour = 8'h07;
    pulse_upd();
    chk("R6 irq low with enables off", {7'd0, irq}, 8'h00);
    rd(4'd12, d); chk("R4 update flag, R3 no alarm", d, 8'h10);
    rd(4'd12, d); chk("R7 cleared after read", d, 8'h00);
  endtask

  task automatic t_match_no_strobe();
    logic [7:0] d;
    cur_sec = 8'h45; cur_min = 8'h30; cur_hour = 8'h07;
    repeat (4) @(negedge clk);
    rd(4'd12, d); chk("R3 no flag without strobe", d, 8'h00);
  endtask

  task automatic t_alarm_match();
    logic [7:0] d;
    en_alm = 1'b1;
    pulse_upd();
    chk("R9 irq on alarm", {7'd0, irq}, 8'h01);
    rd(4'd12, d); chk("R3 alarm match", d, 8'hB0);
    chk("R9 irq low after read", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_wildcard();
    logic [7:0] d;
    wr(4'd1, 8'hC0); wr(4'd3, 8'hFF); wr(4'd5, 8'h07);
    cur_sec = 8'h37; cur_min = 8'h12; cur_hour = 8'h07;
    pulse_upd();
    rd(4'd12, d); chk("R2 wildcard match", d, 8'hB0);
    cur_hour = 8'h08;
    pulse_upd();
    rd(4'd12, d); chk("R3 hour mismatch blocks alarm", d, 8'h10);
    wr(4'd3, 8'h80); cur_hour = 8'h07;
    pulse_upd();
    rd(4'd12, d); chk("R2 0x80 is not wildcard", d, 8'h10);
    en_alm = 1'b0;
  endtask

  task automatic t_periodic();
    logic [7:0] d;
    en_per = 1'b1;
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
    chk("R5 R9 irq on tick", {7'd0, irq}, 8'h01);
    rd(4'd12, d);
    chk("R5 periodic flag", d, 8'hC0);
    chk("R10 low bits zero", {4'h0, d[3:0]}, 8'h00);
    en_per = 1'b0;
  endtask

  task automatic t_enable_toggle();
    logic [7:0] d;
    pulse_upd();
    chk("R6 no irq, enable off", {7'd0, irq}, 8'h00);
    @(negedge clk); en_upd = 1'b1; #1;
    chk("R6 irq follows enable", {7'd0, irq}, 8'h01);
    rd(4'd12, d); chk("R6 summary bit", d, 8'h90);
    en_upd = 1'b0;
  endtask

  task automatic t_collision();
    logic [7:0] d;
    pulse_upd();
    @(negedge clk); rd_en = 1'b1; addr = 4'd12; per_tick = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; per_tick = 1'b0;
    chk("R7 read returns pre-clear", d, 8'h10);
    rd(4'd12, d); chk("R8 event survives clear", d, 8'h40);
    rd(4'd12, d); chk("R7 then clear", d, 8'h00);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alarm_regs();
    t_update_no_enable();
    t_match_no_strobe();
    t_alarm_match();
    t_wildcard();
    t_periodic();
    t_enable_toggle();
    t_collision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule